// File: doc/BRIEF.md
# DMA Channel Idle Watchdog

This block guards a DMA channel against stalls. It watches two activity strobes: one from the memory side of the channel and one from the stream side. Each side has its own idle counter. A single programmable prescaler drives both counters, so they advance once every P+1 clock cycles.

While the channel is busy and the watchdog is enabled, a side's counter returns to zero on every activity strobe from that side. Otherwise it climbs one step per prescaled tick. When it reaches the programmed limit, the sticky timeout flag for that side is set. Software clears a flag by writing one to its clear bit.

The all-ones limit code is not a limit. It is a command that clears both counters and both flags for as long as it is applied. An idle channel, meaning busy is low, never times out.

Top module: `dma_idle_watchdog`

## Requirements
- R1: After reset both timeout flags read 0.
- R2: With prescale value P (0 to 4095) and limit L (0 to 0xFFE), enable and busy high, no activity, and the prescaler phase settled, the flags first read 1 after clock edge number L*(P+1)+1. Edge 1 is the first edge at which enable is high.
- R3: A set flag stays at 1 until its clear bit is written, the 0xFFF limit command is applied, or reset. Dropping enable or busy does not clear it.
- R4: An activity strobe on one side returns only that side's counter to zero. The other side's counter continues without change.
- R5: While busy is low, both counters are held at zero and no flag becomes set.
- R6: While enable is low, neither counter advances and no flag becomes set.
- R7: Clear-bit vector bit 0 clears the memory-side flag and bit 1 clears the stream-side flag. Each bit leaves the other flag unchanged. A clear in the same cycle as a set condition wins for that cycle.
- R8: A limit of 0xFFF clears both flags after the next edge. While it is held, both counters stay at zero and no flag is set.
- R9: A change of the prescale value restarts the prescaler from zero at the next edge. No tick is issued on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_enable | input | 1 | Enables both idle counters |
| tick_div | input | 12 | Prescale value P; one tick every P+1 cycles |
| idle_limit | input | 12 | Timeout limit in ticks; 0xFFF clears both timers |
| chan_busy | input | 1 | Channel busy; counting only while high |
| mem_act | input | 1 | Memory-side activity strobe |
| strm_act | input | 1 | Stream-side activity strobe |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 memory, bit 1 stream |
| mem_timeout | output | 1 | Sticky memory-side timeout flag |
| strm_timeout | output | 1 | Sticky stream-side timeout flag |

## Verification
The expected time to a timeout follows exactly from P and L. A miscounting prescaler or counter therefore shows up as a flag that rises one or more edges early or late, at the first timeout of each table entry. A counter that fails to reset on activity, or one that keeps counting while busy is low, shows up as a flag on the wrong side, or a flag that appears during a long idle window. A broken restart on a prescale change moves the flag by a full prescale period inside a handful of cycles.

// File: rtl/idle_wd_pkg.sv
package idle_wd_pkg;
  localparam int unsigned CNT_W     = 12;
  localparam int unsigned NUM_SIDES = 2;
  typedef enum logic [0:0] {
    SIDE_MEM  = 1'b0,
    SIDE_STRM = 1'b1
  } wd_side_e;
endpackage

// File: rtl/wd_tick_gen.sv
module wd_tick_gen #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pcnt_q, pcnt_d;
  logic [DIV_W-1:0] div_q;
  logic             restart;
  logic             at_end;

  assign restart = !en || (div != div_q);
  assign at_end  = (pcnt_q == div);
  assign tick    = !restart && at_end;

  always_comb begin
    if (restart || at_end) pcnt_d = '0;
    else                   pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      div_q  <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      div_q  <= div;
    end
  end

  // R2: after a tick the divider starts a new period
  p_tick_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pcnt_q == '0));
  // R9: a changed prescale value leaves the phase at zero
  p_div_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (div != div_q) |=> (pcnt_q == '0));
  // R6: disabled divider holds at zero
  p_off_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pcnt_q == '0));
endmodule

// File: rtl/wd_side_timer.sv
module wd_side_timer #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             busy,
  input  logic             clr_all,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  input  logic             activity,
  input  logic             w1c,
  output logic             flag
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             hold_zero;
  logic             reached;

  assign hold_zero = !en || !busy || clr_all || activity;
  assign reached   = (cnt_q == limit);

  always_comb begin
    if (hold_zero)              cnt_d = '0;
    else if (tick && !reached)  cnt_d = cnt_q + 1'b1;
    else                        cnt_d = cnt_q;
  end

  always_comb begin
    if (clr_all || w1c)          flag_d = 1'b0;
    else if (!hold_zero && reached) flag_d = 1'b1;
    else                         flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  // R2: an idle tick below the limit advances by exactly one
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && busy && !clr_all && !activity && tick && (cnt_q != limit))
      |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R3: a set flag survives unless cleared
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !w1c && !clr_all) |=> flag_q);
  // R4: activity returns this side to zero
  p_act_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> (cnt_q == '0));
  // R5: idle channel holds counter at zero and never sets the flag
  p_busy_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ((cnt_q == '0) && !$rose(flag_q)));
  // R6: disabled timer never sets its flag
  p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !$rose(flag_q));
  // R7 / R8: clears take effect at the next edge
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c || clr_all) |=> !flag_q);
endmodule

// File: rtl/dma_idle_watchdog.sv
module dma_idle_watchdog
  import idle_wd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wd_enable,
  input  logic [CNT_W-1:0]  tick_div,
  input  logic [CNT_W-1:0]  idle_limit,
  input  logic              chan_busy,
  input  logic              mem_act,
  input  logic              strm_act,
  input  logic [NUM_SIDES-1:0] flag_clr,
  output logic              mem_timeout,
  output logic              strm_timeout
);
  localparam logic [CNT_W-1:0] CLEAR_CODE = {CNT_W{1'b1}};

  logic                 tick;
  logic                 clr_all;
  logic [NUM_SIDES-1:0] act_vec;
  logic [NUM_SIDES-1:0] flag_vec;

  assign clr_all            = (idle_limit == CLEAR_CODE);
  assign act_vec[SIDE_MEM]  = mem_act;
  assign act_vec[SIDE_STRM] = strm_act;

  wd_tick_gen #(.DIV_W(CNT_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (wd_enable),
    .div  (tick_div),
    .tick (tick)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    wd_side_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (wd_enable),
      .busy    (chan_busy),
      .clr_all (clr_all),
      .tick    (tick),
      .limit   (idle_limit),
      .activity(act_vec[s]),
      .w1c     (flag_clr[s]),
      .flag    (flag_vec[s])
    );
  end

  assign mem_timeout  = flag_vec[SIDE_MEM];
  assign strm_timeout = flag_vec[SIDE_STRM];

  // R8: clear command empties both flags
  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (flag_vec == '0));
  // R4: memory strobe alone cannot change a stream flag that is not being cleared
  p_side_indep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strm_timeout && !flag_clr[SIDE_STRM] && !clr_all) |=> strm_timeout);
endmodule

// File: tb/dma_idle_watchdog_test.sv
module dma_idle_watchdog_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wd_enable;
  logic [11:0] tick_div;
  logic [11:0] idle_limit;
  logic        chan_busy;
  logic        mem_act;
  logic        strm_act;
  logic [1:0]  flag_clr;
  logic        mem_timeout;
  logic        strm_timeout;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // {P, L} pairs walked by the main loop (R2)
  localparam int NVEC = 7;
  localparam int VEC [NVEC][2] = '{
    '{0, 0}, '{0, 5}, '{1, 3}, '{3, 2}, '{2, 7}, '{4095, 1}, '{0, 4094}
  };

  always #4 clk = ~clk;

  dma_idle_watchdog uut (
    .clk(clk), .rst_n(rst_n), .wd_enable(wd_enable), .tick_div(tick_div),
    .idle_limit(idle_limit), .chan_busy(chan_busy), .mem_act(mem_act),
    .strm_act(strm_act), .flag_clr(flag_clr), .mem_timeout(mem_timeout),
    .strm_timeout(strm_timeout)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
      finish_run();
    end
  end

  // advance n edges, then settle 2 ns after the last one
  task automatic cyc(int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [1:0] exp);
    logic [1:0] got;
    got = {strm_timeout, mem_timeout};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: flags {strm,mem} actual %b expected %b", req, got, exp);
    end
  endtask

  task automatic quiesce(int p, int l);
    wd_enable = 1'b0; chan_busy = 1'b0; flag_clr = 2'b11;
    cyc(1);
    flag_clr = 2'b00; tick_div = 12'(p); idle_limit = 12'(l);
    cyc(2);
  endtask

  initial begin
    rst_n = 1'b0; wd_enable = 1'b0; tick_div = '0; idle_limit = '0;
    chan_busy = 1'b0; mem_act = 1'b0; strm_act = 1'b0; flag_clr = '0;
    cyc(3);
    chk("R1", 2'b00);
    rst_n = 1'b1;
    cyc(1);
    chk("R1", 2'b00);

    // R2: table of prescale/limit pairs
    for (int i = 0; i < NVEC; i++) begin
      int t;
      t = VEC[i][1] * (VEC[i][0] + 1) + 1;
      quiesce(VEC[i][0], VEC[i][1]);
      wd_enable = 1'b1; chan_busy = 1'b1;
      cyc(t - 1);
      chk("R2", 2'b00);
      cyc(1);
      chk("R2", 2'b11);
    end

    // R4: memory strobe restarts only the memory side
    quiesce(0, 10);
    wd_enable = 1'b1; chan_busy = 1'b1;
    cyc(8);
    mem_act = 1'b1;
    cyc(1);
    mem_act = 1'b0;
    cyc(2);
    chk("R4", 2'b10);
    cyc(8);
    chk("R4", 2'b10);
    cyc(1);
    chk("R4", 2'b11);

    // R3: flags survive dropping enable
    wd_enable = 1'b0;
    cyc(5);
    chk("R3", 2'b11);
    chan_busy = 1'b0;
    cyc(3);
    chk("R3", 2'b11);

    // R6: disabled with busy high and limit 0, nothing sets
    flag_clr = 2'b11;
    cyc(1);
    flag_clr = 2'b00; idle_limit = 12'd0; chan_busy = 1'b1;
    cyc(10);
    chk("R6", 2'b00);

    // R7: per-bit clear, clear wins over set
    wd_enable = 1'b1;
    cyc(2);
    chk("R7", 2'b11);
    flag_clr = 2'b01;
    cyc(1);
    chk("R7", 2'b10);
    flag_clr = 2'b00;
    cyc(1);
    chk("R7", 2'b11);
    chan_busy = 1'b0; flag_clr = 2'b10;
    cyc(1);
    flag_clr = 2'b00;
    chk("R7", 2'b01);
    cyc(3);
    chk("R5", 2'b01);

    // R5: long idle window with busy low
    flag_clr = 2'b11;
    cyc(1);
    flag_clr = 2'b00; idle_limit = 12'd2; tick_div = 12'd0;
    cyc(50);
    chk("R5", 2'b00);

    // R8: all-ones limit clears and holds
    chan_busy = 1'b1;
    cyc(4);
    chk("R8", 2'b11);
    idle_limit = 12'hFFF;
    cyc(1);
    chk("R8", 2'b00);
    cyc(40);
    chk("R8", 2'b00);
    idle_limit = 12'd2;
    cyc(2);
    chk("R8", 2'b00);
    cyc(1);
    chk("R8", 2'b11);

    // R9: prescale change mid-period restarts the divider
    quiesce(3, 1);
    wd_enable = 1'b1; chan_busy = 1'b1;
    cyc(2);
    tick_div = 12'd2;
    cyc(4);
    chk("R9", 2'b00);
    cyc(1);
    chk("R9", 2'b11);

    finish_run();
  end
endmodule